// File: doc/BRIEF.md
# Wrapping Burst Line-Fill Sequencer

This block refills one cache line from memory after a miss. A miss request carries the word address that missed. The sequencer then reads every word of that line over a burst of exactly `WORDS` accepted beats. The burst starts at the missed word and wraps around the line boundary. The direction of the burst depends on the low bit of the missed address. When the missed word sits at an even offset, the word offset counts upward. When it sits at an odd offset, the offset counts downward. Either way, all words of the line arrive once per fill.

Each returning word is captured in a line buffer. The missed word is always the first beat, so it is handed to the CPU in the cycle it arrives from memory. The CPU can therefore restart long before the fill completes. After the last beat, the whole buffered line is written to the cache array in a single cycle. In the following cycle a completion pulse marks the line valid. A miss request that arrives while a fill is in flight is dropped.

Top module: `lf_burst_fill`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req`, `cpu_vld`, `line_wr` and `fill_done` are all 0.
- R2: In the cycle after an accepted miss, `mem_req` is 1 and `mem_addr` equals the missed word address.
- R3: When the missed word offset (`miss_addr` modulo `WORDS`) is even, beat k requests offset (start + k) modulo `WORDS`.
- R4: When the missed word offset is odd, beat k requests offset (start − k) modulo `WORDS`.
- R5: The line part of `mem_addr` (all bits above the offset) equals the missed line for every beat of a fill.
- R6: With `CPU_BYPASS`=1, `cpu_vld` is 1 for exactly one cycle per fill. That cycle is the one in which the first beat is accepted (`mem_req` and `mem_rvalid` both 1). In that cycle `cpu_data` equals `mem_rdata`.
- R7: A cycle with `mem_req` 1 and `mem_rvalid` 0 does not advance the burst: `mem_addr` holds its value into the next cycle.
- R8: `line_wr` is 1 for one cycle, directly after the cycle of the last accepted beat. In that cycle `line_addr` is `miss_addr` shifted right by log2(`WORDS`). Bits [i*DATA_W +: DATA_W] of `line_data` hold the memory word at line offset i.
- R9: `fill_done`, which marks the line valid, is 1 for one cycle directly after `line_wr` and never at any other time.
- R10: `busy` is 1 from the cycle after an accepted miss through the `fill_done` cycle. A `miss_req` seen while `busy` is 1 changes neither the burst addresses nor the written line, and it does not start a new fill.
- R11: Each fill accepts exactly `WORDS` beats. `mem_req` falls after the last accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Miss request, taken only when idle |
| miss_addr | input | ADDR_W | Word address that missed |
| busy | output | 1 | A fill is in progress |
| mem_req | output | 1 | Memory read beat requested |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_rvalid | input | 1 | Memory returns the current beat |
| mem_rdata | input | DATA_W | Data of the current beat |
| cpu_vld | output | 1 | Missed word is being returned to the CPU |
| cpu_data | output | DATA_W | Missed word data |
| line_wr | output | 1 | Write full line into cache array |
| line_addr | output | ADDR_W-log2(WORDS) | Line index for the array write |
| line_data | output | WORDS*DATA_W | Full line, word i at bits i*DATA_W |
| fill_done | output | 1 | Fill complete; line marked valid |

## Verification
The bench builds the block with `WORDS`=4, `ADDR_W`=8, `DATA_W`=16 and `CPU_BYPASS`=1. This small address space lets the bench issue a fill for every one of the 256 possible miss addresses. That covers all four start offsets, and so both burst directions, in every line. Memory data is a fixed arithmetic function of the address, so each beat address and each word of the written line can be predicted exactly. Fills alternate between back-to-back beats and stalled beats, and some fills have a competing miss request held throughout. This exercises address holding and the rule that a request during a fill is dropped.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } lf_state_e;
endpackage

// File: rtl/lf_addr_gen.sv
module lf_addr_gen #(
   parameter int ADDR_W = 8,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-$clog2(WORDS)-1:0] line_idx
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);

   logic [LINE_W-1:0] line_q;
   logic [OFF_W-1:0]  off_q;
   logic              down_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         off_q  <= '0;
         down_q <= 1'b0;
      end else if (load) begin
         line_q <= load_addr[ADDR_W-1:OFF_W];
         off_q  <= load_addr[OFF_W-1:0];
         down_q <= load_addr[0];
      end else if (step) begin
         if (down_q) off_q <= off_q - OFF_ONE;
         else        off_q <= off_q + OFF_ONE;
      end
   end

   assign cur_addr = {line_q, off_q};
   assign line_idx = line_q;
endmodule

// File: rtl/lf_line_buf.sv
module lf_line_buf #(
   parameter int DATA_W = 16,
   parameter int WORDS  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(WORDS)-1:0] wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [WORDS*DATA_W-1:0] line_flat
);
   localparam int OFF_W = $clog2(WORDS);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                word_q <= '0;
         else if (wr_en && wr_idx == OFF_W'(i))    word_q <= wr_data;
      end
      assign line_flat[i*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl #(
   parameter int WORDS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_req,
   input  logic beat_in,
   output logic load,
   output logic fetching,
   output logic first_beat,
   output logic line_wr,
   output logic fill_done,
   output logic busy
);
   import lf_pkg::*;
   localparam int OFF_W = $clog2(WORDS);
   localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);
   localparam logic [OFF_W-1:0] CNT_ONE  = OFF_W'(1);

   lf_state_e        state_q, state_d;
   logic [OFF_W-1:0] cnt_q;
   logic             beat_ok, last_beat;

   assign fetching   = (state_q == ST_FETCH);
   assign beat_ok    = fetching && beat_in;
   assign last_beat  = beat_ok && (cnt_q == LAST_CNT);
   assign first_beat = fetching && (cnt_q == '0);
   assign load       = (state_q == ST_IDLE) && miss_req;
   assign line_wr    = (state_q == ST_WRITE);
   assign fill_done  = (state_q == ST_DONE);
   assign busy       = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (miss_req)  state_d = ST_FETCH;
         ST_FETCH: if (last_beat) state_d = ST_WRITE;
         ST_WRITE:                state_d = ST_DONE;
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (load)         cnt_q <= '0;
         else if (beat_ok) cnt_q <= cnt_q + CNT_ONE;
      end
   end
endmodule

// File: rtl/lf_burst_fill.sv
module lf_burst_fill #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int WORDS      = 4,
   parameter bit CPU_BYPASS = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        miss_req,
   input  logic [ADDR_W-1:0]           miss_addr,
   output logic                        busy,
   output logic                        mem_req,
   output logic [ADDR_W-1:0]           mem_addr,
   input  logic                        mem_rvalid,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic                        cpu_vld,
   output logic [DATA_W-1:0]           cpu_data,
   output logic                        line_wr,
   output logic [ADDR_W-$clog2(WORDS)-1:0] line_addr,
   output logic [WORDS*DATA_W-1:0]     line_data,
   output logic                        fill_done
);
   localparam int OFF_W = $clog2(WORDS);

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("lf_burst_fill: WORDS must be a power of two, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("lf_burst_fill: ADDR_W must exceed log2(WORDS)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("lf_burst_fill: DATA_W must be positive");
   end

   logic load, fetching, first_beat, beat;

   lf_ctrl #(.WORDS(WORDS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .miss_req  (miss_req),
      .beat_in   (mem_rvalid),
      .load      (load),
      .fetching  (fetching),
      .first_beat(first_beat),
      .line_wr   (line_wr),
      .fill_done (fill_done),
      .busy      (busy)
   );

   assign beat    = fetching && mem_rvalid;
   assign mem_req = fetching;

   lf_addr_gen #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_addr(miss_addr),
      .step     (beat),
      .cur_addr (mem_addr),
      .line_idx (line_addr)
   );

   lf_line_buf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (beat),
      .wr_idx   (mem_addr[OFF_W-1:0]),
      .wr_data  (mem_rdata),
      .line_flat(line_data)
   );

   if (CPU_BYPASS) begin : g_fwd_bypass
      assign cpu_vld  = beat && first_beat;
      assign cpu_data = mem_rdata;
   end else begin : g_fwd_buffered
      logic             vld_q;
      logic [OFF_W-1:0] first_off_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q       <= 1'b0;
            first_off_q <= '0;
         end else begin
            vld_q <= beat && first_beat;
            if (load) first_off_q <= miss_addr[OFF_W-1:0];
         end
      end
      assign cpu_vld  = vld_q;
      assign cpu_data = line_data[first_off_q*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/lf_burst_fill_chk.sv
module lf_burst_fill_chk #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int WORDS      = 4,
   parameter bit CPU_BYPASS = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    miss_req,
   input logic [ADDR_W-1:0]       miss_addr,
   input logic                    busy,
   input logic                    mem_req,
   input logic [ADDR_W-1:0]       mem_addr,
   input logic                    mem_rvalid,
   input logic [DATA_W-1:0]       mem_rdata,
   input logic                    cpu_vld,
   input logic                    line_wr,
   input logic                    fill_done
);
   localparam int OFF_W = $clog2(WORDS);
   localparam int CW    = OFF_W + 1;

   logic [CW-1:0] beats_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                     beats_q <= '0;
      else if (fill_done)             beats_q <= '0;
      else if (mem_req && mem_rvalid) beats_q <= beats_q + CW'(1);
   end

   a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_req) |=> (mem_req && mem_addr == $past(miss_addr)));

   a_r5_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

   a_r6_cpu_single: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_vld |=> !cpu_vld);

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> $stable(mem_addr));

   a_r8_wr_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
      line_wr |-> (!mem_req && $past(mem_req && mem_rvalid)));

   a_r9_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> $past(line_wr));

   a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || line_wr || fill_done) |-> busy);

   a_r11_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
      line_wr |-> (beats_q == CW'(WORDS)));

   a_r1_onehot_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, line_wr, fill_done}));

   logic unused_ok;
   assign unused_ok = ^{mem_rdata, CPU_BYPASS};
endmodule

bind lf_burst_fill lf_burst_fill_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .CPU_BYPASS(CPU_BYPASS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
   .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cpu_vld(cpu_vld),
   .line_wr(line_wr), .fill_done(fill_done)
);

// File: tb/tb_lf_burst_fill.sv
module tb_lf_burst_fill;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            miss_req = 1'b0;
   logic [AW-1:0]   miss_addr = '0;
   logic            busy, mem_req, cpu_vld, line_wr, fill_done;
   logic [AW-1:0]   mem_addr;
   logic            mem_rvalid = 1'b0;
   logic [DW-1:0]   mem_rdata = '0;
   logic [DW-1:0]   cpu_data;
   logic [AW-3:0]   line_addr;
   logic [NW*DW-1:0] line_data;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   lf_burst_fill #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW), .CPU_BYPASS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .cpu_vld(cpu_vld), .cpu_data(cpu_data),
      .line_wr(line_wr), .line_addr(line_addr), .line_data(line_data),
      .fill_done(fill_done)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return DW'(int'(a) * 59 + 16'h1234);
   endfunction

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k);
      int off0 = int'(a) % NW;
      int off  = a[0] ? (off0 - k + 4 * NW) % NW : (off0 + k) % NW;
      return (a & ~AW'(NW - 1)) | AW'(off);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_fill(input logic [AW-1:0] a, input bit stall, input bit inject);
      int k = 0;
      int n = 0;
      @(negedge clk);
      miss_req  = 1'b1;
      miss_addr = a;
      @(negedge clk);
      miss_req  = inject;
      miss_addr = a ^ 8'h55;
      #1;
      chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
      while (k < NW) begin
         if (n > 0) @(negedge clk);
         mem_rvalid = !(stall && (n % 3 == 1));
         mem_rdata  = memf(mem_addr);
         #1;
         chk(mem_req == 1'b1, "R11 mem_req during burst", 64'(mem_req), 64'd1);
         if (k == 0)
            chk(mem_addr == a, "R2 first beat address", 64'(mem_addr), 64'(a));
         else if (a[0])
            chk(mem_addr == exp_addr(a, k), "R4 odd start order", 64'(mem_addr),
                64'(exp_addr(a, k)));
         else
            chk(mem_addr == exp_addr(a, k), "R3 even start order", 64'(mem_addr),
                64'(exp_addr(a, k)));
         chk(mem_addr[AW-1:2] == a[AW-1:2], "R5 line bits", 64'(mem_addr[AW-1:2]),
             64'(a[AW-1:2]));
         if (!mem_rvalid)
            chk(mem_addr == exp_addr(a, k), "R7 stall holds address", 64'(mem_addr),
                64'(exp_addr(a, k)));
         chk(cpu_vld == (mem_rvalid && k == 0), "R6 cpu_vld timing", 64'(cpu_vld),
             64'(mem_rvalid && k == 0));
         if (cpu_vld)
            chk(cpu_data == memf(a), "R6 cpu_data", 64'(cpu_data), 64'(memf(a)));
         chk(line_wr == 1'b0 && fill_done == 1'b0, "R9 no early write",
             64'({line_wr, fill_done}), 64'd0);
         if (mem_rvalid) k++;
         n++;
      end
      @(negedge clk);
      mem_rvalid = 1'b0;
      miss_req   = 1'b0;
      #1;
      chk(line_wr == 1'b1, "R8 line_wr after last beat", 64'(line_wr), 64'd1);
      chk(mem_req == 1'b0, "R11 mem_req falls", 64'(mem_req), 64'd0);
      chk(fill_done == 1'b0, "R9 done not with write", 64'(fill_done), 64'd0);
      chk(line_addr == a[AW-1:2], "R8 line_addr", 64'(line_addr), 64'(a[AW-1:2]));
      for (int i = 0; i < NW; i++) begin
         logic [AW-1:0] wa = {a[AW-1:2], 2'(i)};
         chk(line_data[i*DW +: DW] == memf(wa), "R8 line word", 64'(line_data[i*DW +: DW]),
             64'(memf(wa)));
      end
      @(negedge clk);
      #1;
      chk(fill_done == 1'b1 && line_wr == 1'b0, "R9 done after write",
          64'({fill_done, line_wr}), 64'b10);
      chk(busy == 1'b1, "R10 busy through done", 64'(busy), 64'd1);
      @(negedge clk);
      #1;
      chk(busy == 1'b0 && fill_done == 1'b0, "R10 idle after done",
          64'({busy, fill_done}), 64'd0);
      if (inject) begin
         @(negedge clk);
         #1;
         chk(busy == 1'b0 && mem_req == 1'b0, "R10 dropped request starts nothing",
             64'({busy, mem_req}), 64'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk({busy, mem_req, cpu_vld, line_wr, fill_done} == 5'b0, "R1 reset outputs",
          64'({busy, mem_req, cpu_vld, line_wr, fill_done}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk({busy, mem_req, cpu_vld, line_wr, fill_done} == 5'b0, "R1 after reset",
          64'({busy, mem_req, cpu_vld, line_wr, fill_done}), 64'd0);
      for (int a = 0; a < (1 << AW); a++) begin
         logic [AW-1:0] av = AW'(a);
         do_fill(av, av[2], av[3] & av[4]);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule